// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is an eight-stage shift register that is loaded in parallel and read out serially. It runs entirely on one system clock. An external shift clock and a clock-inhibit input come in without any timing relation to that clock. Each passes through a two-flop synchroniser. The block ORs the two synchronised levels and shifts once for every low-to-high change of that OR. Either input can therefore act as the clock while the other is held low.

An active-low load control has priority over everything else. While it is low, every stage follows its own parallel input on every system clock, whatever the shift clock, inhibit and serial inputs are doing. While it is high, the parallel inputs are ignored. Each qualifying edge then moves data one stage toward the last stage, and the serial input enters the first stage. The last stage drives a true output and a complemented output. Several blocks can be chained by feeding one block's true output into the next block's serial input.

Top module: `psr_shift8`

## Requirements
- R1: While reset is high on a system clock edge, all stages are cleared. After that edge the true output is 0 and the complemented output is 1.
- R2: While the load control is low, stage i takes parallel input bit i on every system clock edge. Bit 0 is the first stage and bit 7 is the last stage. The shift clock, inhibit and serial inputs have no effect during this time.
- R3: While the load control is high, each 0-to-1 change of the OR of the synchronised shift clock and inhibit produces exactly one shift. The shift takes effect on the third system clock edge after the input changes. A falling edge produces no shift.
- R4: On a shift, the serial input enters stage 0 and every other stage takes the value of the stage before it. After a load of pattern P followed by k shifts (k < 8), the true output equals P[7-k]. After 8 shifts it equals the serial value that was shifted in first.
- R5: While the inhibit input is held high, rising edges of the shift clock cause no shift.
- R6: A rising edge of the inhibit input while the shift clock is low causes exactly one shift.
- R7: The complemented output is always the inverse of the true output.
- R8: A rising edge of the OR that happens while the load control is low is not counted. After the load control returns high, the loaded value is kept until the next new rising edge.
- R9: While the load control is high, changes on the parallel inputs have no effect on the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| ext_clk | input | 1 | Asynchronous shift clock |
| ext_inh | input | 1 | Asynchronous clock inhibit, ORed with the shift clock |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | 8 | Parallel data; bit 0 is the first stage |
| qh | output | 1 | Last-stage value |
| qh_n | output | 1 | Complement of the last-stage value |

## Verification
On every cycle, the assertions check the stage register's behaviour:
- It copies the parallel inputs under load.
- It moves exactly one position per shift pulse, with the serial bit entering stage 0.
- It holds otherwise.
- It is cleared by reset.
- The edge detector never produces two pulses in a row, and never pulses while the synchronised inhibit stays high.

Only the bench scenarios can show the behaviour at the block's edge:
- the serial order of a whole shifted-out pattern;
- the discarding of an edge that arrived during load;
- the equivalence of the clock and inhibit inputs;
- the synchroniser latency as seen at the ports.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned PSR_WIDTH       = 8;
    localparam int unsigned PSR_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } psr_op_e;

    typedef struct packed {
        logic clk_lvl;
        logic inh_lvl;
    } psr_clk_pair_t;

    // Load has absolute priority; a shift needs load released and a pulse.
    function automatic psr_op_e psr_decode(input logic load_n, input logic pulse);
        if (!load_n)
            return OP_LOAD;
        else if (pulse)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain[0] <= '0;
        else
            chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else
                chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/psr_clk_edge.sv
module psr_clk_edge
    import psr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = PSR_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_inh,
    output logic shift_pulse
);

    psr_clk_pair_t raw_pair;
    psr_clk_pair_t sync_pair;
    logic          or_now;
    logic          or_prev;

    assign raw_pair.clk_lvl = ext_clk;
    assign raw_pair.inh_lvl = ext_inh;

    psr_sync #(
        .WIDTH  ($bits(psr_clk_pair_t)),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pair),
        .q   (sync_pair)
    );

    assign or_now = sync_pair.clk_lvl | sync_pair.inh_lvl;

    always_ff @(posedge clk) begin
        if (rst)
            or_prev <= 1'b0;
        else
            or_prev <= or_now;
    end

    assign shift_pulse = or_now & ~or_prev;

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);

    // R5
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sync_pair.inh_lvl) && sync_pair.inh_lvl) |-> !shift_pulse);

endmodule

// File: rtl/psr_stages.sv
module psr_stages
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH = PSR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             shift_pulse,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages
);

    psr_op_e          op;
    logic [WIDTH-1:0] shift_src;
    logic [WIDTH-1:0] nxt;

    assign op = psr_decode(load_n, shift_pulse);

    assign shift_src[0] = ser_in;
    for (genvar i = 1; i < WIDTH; i++) begin : g_link
        assign shift_src[i] = stages[i-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op)
                OP_LOAD:  nxt[i] = par_in[i];
                OP_SHIFT: nxt[i] = shift_src[i];
                default:  nxt[i] = stages[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stages <= '0;
        else
            stages <= nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stages == '0));

    // R2
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (stages == $past(par_in)));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && shift_pulse) |=>
            (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_pulse) |=> $stable(stages));

endmodule

// File: rtl/psr_shift8.sv
module psr_shift8
    import psr_pkg::*;
#(
    parameter int unsigned WIDTH       = PSR_WIDTH,
    parameter int unsigned SYNC_STAGES = PSR_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             ext_clk,
    input  logic             ext_inh,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             qh,
    output logic             qh_n
);

    localparam int unsigned LAST = WIDTH - 1;

    logic             shift_pulse;
    logic [WIDTH-1:0] stages;

    psr_clk_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk         (clk),
        .rst         (rst),
        .ext_clk     (ext_clk),
        .ext_inh     (ext_inh),
        .shift_pulse (shift_pulse)
    );

    psr_stages #(
        .WIDTH (WIDTH)
    ) u_stages (
        .clk         (clk),
        .rst         (rst),
        .load_n      (load_n),
        .shift_pulse (shift_pulse),
        .ser_in      (ser_in),
        .par_in      (par_in),
        .stages      (stages)
    );

    assign qh   = stages[LAST];
    assign qh_n = ~stages[LAST];

endmodule

// File: tb/psr_shift8_tb.sv
module psr_shift8_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic       ext_clk = 1'b0;
    logic       ext_inh = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       qh;
    logic       qh_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    psr_shift8 u_dut (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n),
        .ext_clk (ext_clk),
        .ext_inh (ext_inh),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .qh      (qh),
        .qh_n    (qh_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_q(input string req, input logic exp);
        n_checks++;
        if (qh !== exp) begin
            n_fails++;
            $display("FAIL %s qh actual=%b expected=%b", req, qh, exp);
        end
        n_checks++;
        // R7
        if (qh_n !== ~exp) begin
            n_fails++;
            $display("FAIL R7 qh_n actual=%b expected=%b", qh_n, ~exp);
        end
    endtask

    task automatic load(input logic [7:0] p);
        load_n = 1'b0;
        par_in = p;
        tick(2);
        load_n = 1'b1;
        tick(1);
    endtask

    task automatic pulse_clk();
        ext_clk = 1'b1;
        tick(4);
        ext_clk = 1'b0;
        tick(4);
    endtask

    task automatic pulse_inh();
        ext_inh = 1'b1;
        tick(4);
        ext_inh = 1'b0;
        tick(4);
    endtask

    task automatic t_reset();
        load(8'hFF);
        rst = 1'b1;
        tick(3);
        check_q("R1", 1'b0);
        rst = 1'b0;
        tick(1);
        check_q("R1", 1'b0);
    endtask

    task automatic t_load_priority();
        logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'h81};
        load_n = 1'b0;
        foreach (pats[j]) begin
            par_in = pats[j];
            ext_clk = ~ext_clk;
            ser_in  = ~ser_in;
            tick(5);
            check_q("R2", pats[j][7]);
        end
        ext_clk = 1'b0;
        tick(5);
        load_n = 1'b1;
        tick(5);
    endtask

    task automatic t_shift_out(input logic [7:0] p, input logic [7:0] sbits);
        load(p);
        for (int k = 0; k <= 8; k++) begin
            if (k < 8) check_q("R4", p[7-k]);
            else       check_q("R4", sbits[0]);
            if (k < 8) begin
                ser_in = sbits[k];
                pulse_clk();
            end
        end
    endtask

    task automatic t_latency();
        load(8'b1100_0000);
        ext_clk = 1'b1;
        tick(2);
        check_q("R3", 1'b1);
        tick(1);
        check_q("R3", 1'b1);
        ext_clk = 1'b0;
        tick(6);
        check_q("R3", 1'b1);
        ext_clk = 1'b1;
        tick(6);
        check_q("R3", 1'b0);
        ext_clk = 1'b0;
        tick(4);
    endtask

    task automatic t_inhibit_and_pending();
        logic [7:0] p = 8'b0110_1001;
        load_n = 1'b0;
        par_in = p;
        ext_inh = 1'b1;
        tick(6);
        load_n = 1'b1;
        tick(6);
        check_q("R8", p[7]);
        for (int j = 0; j < 3; j++) pulse_clk();
        check_q("R5", p[7]);
        ext_inh = 1'b0;
        tick(6);
        check_q("R5", p[7]);
        pulse_clk();
        check_q("R8", p[6]);
    endtask

    task automatic t_inh_as_clock();
        logic [7:0] p = 8'b1010_0000;
        load(p);
        pulse_inh();
        check_q("R6", p[6]);
        pulse_inh();
        check_q("R6", p[5]);
    endtask

    task automatic t_par_ignored();
        load(8'h80);
        par_in = 8'h00;
        tick(4);
        check_q("R9", 1'b1);
        par_in = 8'h7F;
        tick(4);
        check_q("R9", 1'b1);
    endtask

    initial begin
        rst = 1'b1;
        tick(4);
        check_q("R1", 1'b0);
        rst = 1'b0;
        tick(2);
        t_load_priority();
        t_shift_out(8'hB4, 8'b0000_0001);
        t_shift_out(8'h4B, 8'b1111_1110);
        t_latency();
        t_inhibit_and_pending();
        t_inh_as_clock();
        t_par_ignored();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule